// File: doc/BRIEF.md
# Bridge Response Error Capture Register

This block sits beside an AXI-style bridge and watches its read data channel, its write response channel and a few side-band indications. It classifies each response as clean or faulty, and it records faults as sticky flags in a 64-bit status register. Read-channel fault classes use the low bits, write-channel classes use bits 16 to 19, and traffic aimed at a powered-down interconnect layer uses bit 32.

The register records only the first fault event. It captures the first cycle that contains one or more faults while the register is empty. It then freezes until software clears the captured bits by writing zeros. A tracker state machine follows each read burst (states BURST_IDLE and BURST_OPEN). Transition IDLE to OPEN occurs on a first beat without last. Transition OPEN to IDLE occurs on the last beat of the tracked ID. Only the opening beat of a burst is checked for response code and routing faults, and a foreign-ID beat while the burst is open is an interleave. A capture state machine (CAP_ARMED and CAP_FROZEN) moves from ARMED to FROZEN when any flag becomes set, and from FROZEN to ARMED when software has cleared every flag.

The register port allows only accesses that are both secure and privileged. Any other access returns zero, changes nothing and raises an access-error output.

Top module: `axi_err_capture`

## Requirements
- R1: On the first beat of a read burst, response code 2'b10 sets bit 1 and 2'b11 sets bit 0. Codes 2'b00 and 2'b01 set nothing.
- R2: A read burst opens on a beat with rd_last low while no burst is tracked, and closes on a beat with the tracked ID and rd_last high. Response codes of the beats after the first are ignored.
- R3: rd_route_miss on a first read beat sets bit 2, and a rd_cmd_mod pulse sets bit 4.
- R4: A beat whose ID differs from the open burst's ID, arriving while rd_ilv_ok is low, sets bit 3. With rd_ilv_ok high it sets nothing.
- R5: On a write response beat, code 2'b11 sets bit 16, code 2'b10 sets bit 17, and wr_route_miss sets bit 18. A wr_cmd_mod pulse sets bit 19.
- R6: A gated_hit pulse sets bit 32.
- R7: All bits are 0 after reset. Bits 63:33, 31:20 and 15:5 read as 0 and ignore writes.
- R8: A fault becomes visible on the clock edge that ends the cycle in which it is presented. All faults of that cycle are latched together when the register was empty.
- R9: While any flag is 1, new faults are not recorded, and the status holds unless an accepted write clears bits.
- R10: An accepted write clears each implemented bit written as 0 and leaves bits written as 1 unchanged. Software cannot set a flag.
- R11: An access with reg_secure or reg_priv low raises reg_acc_err in that cycle, reads as 0 and does not change the status.
- R12: reg_rdata shows the status during an accepted read cycle (reg_sel high, reg_wr low) and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Read data beat present |
| rd_id | input | ID_W | ID of the read beat |
| rd_resp | input | 2 | Response code of the read beat |
| rd_last | input | 1 | Final beat of the read burst |
| rd_route_miss | input | 1 | Read ID found no routing destination |
| rd_ilv_ok | input | 1 | Target of the read can interleave (de-interleaver present) |
| rd_cmd_mod | input | 1 | Pulse: non-modifiable read command was altered |
| wr_valid | input | 1 | Write response beat present |
| wr_resp | input | 2 | Response code of the write response |
| wr_route_miss | input | 1 | Write response ID found no routing destination |
| wr_cmd_mod | input | 1 | Pulse: non-modifiable write command was altered |
| gated_hit | input | 1 | Pulse: traffic aimed at a power-gated layer |
| reg_sel | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | Access is a write (else read) |
| reg_secure | input | 1 | Access is secure |
| reg_priv | input | 1 | Access is privileged |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data |
| reg_acc_err | output | 1 | Access refused for protection |

## Verification
The assertions assume that each register access lasts a single cycle and that the protection attributes are valid whenever reg_sel is high. They also assume that the side-band pulses are single-cycle events that are not tied to handshakes. The interleave property assumes that rd_id and rd_ilv_ok are meaningful whenever rd_valid is high. The stimulus drives every input for exactly one clock and returns it to zero. It keeps each burst's beats in order, always closes an opened burst with its own ID, and never presents a fault in the same cycle as a clearing write.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    localparam int STAT_W   = 64;
    localparam int RD_BASE  = 0;
    localparam int WR_BASE  = 16;
    localparam int GATE_BIT = 32;
    localparam int RD_N     = 5;
    localparam int WR_N     = 4;

    // read group offsets
    localparam int RD_DEC   = 0;
    localparam int RD_SLV   = 1;
    localparam int RD_ROUTE = 2;
    localparam int RD_ILV   = 3;
    localparam int RD_MOD   = 4;

    // write group offsets
    localparam int WR_DEC   = 0;
    localparam int WR_SLV   = 1;
    localparam int WR_ROUTE = 2;
    localparam int WR_MOD   = 3;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } resp_e;

    typedef enum logic {
        BURST_IDLE,
        BURST_OPEN
    } burst_st_e;

    typedef enum logic {
        CAP_ARMED,
        CAP_FROZEN
    } cap_st_e;

    function automatic logic [STAT_W-1:0] impl_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int i = 0; i < RD_N; i++) m[RD_BASE+i] = 1'b1;
        for (int i = 0; i < WR_N; i++) m[WR_BASE+i] = 1'b1;
        m[GATE_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [STAT_W-1:0] IMPL_MASK = impl_mask();

endpackage

// File: rtl/rd_err_detect.sv
module rd_err_detect
    import errcap_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_valid,
    input  logic [ID_W-1:0]     rd_id,
    input  logic [1:0]          rd_resp,
    input  logic                rd_last,
    input  logic                rd_route_miss,
    input  logic                rd_ilv_ok,
    input  logic                rd_cmd_mod,
    output logic [RD_N-1:0]     rd_ev,
    output logic                burst_open,
    output logic [ID_W-1:0]     open_id
);

    burst_st_e          state_q, state_d;
    logic [ID_W-1:0]    id_q, id_d;
    logic               first_beat;
    logic               stray_beat;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BURST_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    // transitions: IDLE->OPEN on a non-final first beat,
    // OPEN->IDLE on the final beat of the tracked ID
    always_comb begin
        state_d = state_q;
        id_d    = id_q;
        unique case (state_q)
            BURST_IDLE: begin
                if (rd_valid && !rd_last) begin
                    state_d = BURST_OPEN;
                    id_d    = rd_id;
                end
            end
            BURST_OPEN: begin
                if (rd_valid && (rd_id == id_q) && rd_last) begin
                    state_d = BURST_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        first_beat = rd_valid && (state_q == BURST_IDLE);
        stray_beat = rd_valid && (state_q == BURST_OPEN) && (rd_id != id_q);
        rd_ev           = '0;
        rd_ev[RD_DEC]   = first_beat && (rd_resp == RESP_DECERR);
        rd_ev[RD_SLV]   = first_beat && (rd_resp == RESP_SLVERR);
        rd_ev[RD_ROUTE] = first_beat && rd_route_miss;
        rd_ev[RD_ILV]   = stray_beat && !rd_ilv_ok;
        rd_ev[RD_MOD]   = rd_cmd_mod;
        burst_open      = (state_q == BURST_OPEN);
        open_id         = id_q;
    end

endmodule

// File: rtl/wr_err_detect.sv
module wr_err_detect
    import errcap_pkg::*;
(
    input  logic            wr_valid,
    input  logic [1:0]      wr_resp,
    input  logic            wr_route_miss,
    input  logic            wr_cmd_mod,
    output logic [WR_N-1:0] wr_ev
);

    // every write response is a single beat, so each one is checked
    always_comb begin
        wr_ev           = '0;
        wr_ev[WR_DEC]   = wr_valid && (wr_resp == RESP_DECERR);
        wr_ev[WR_SLV]   = wr_valid && (wr_resp == RESP_SLVERR);
        wr_ev[WR_ROUTE] = wr_valid && wr_route_miss;
        wr_ev[WR_MOD]   = wr_cmd_mod;
    end

endmodule

// File: rtl/err_capture.sv
module err_capture
    import errcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev,
    input  logic              wr_ok,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] status,
    output logic              frozen
);

    cap_st_e            state_q, state_d;
    logic [STAT_W-1:0]  stat_q, stat_d;
    logic [STAT_W-1:0]  captured;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_ARMED;
            stat_q  <= '0;
        end else begin
            state_q <= state_d;
            stat_q  <= stat_d;
        end
    end

    // ARMED: take every fault of the cycle; FROZEN: hold.
    // A clearing write applies after capture in the same cycle.
    always_comb begin
        captured = stat_q;
        unique case (state_q)
            CAP_ARMED:  captured = stat_q | (ev & IMPL_MASK);
            CAP_FROZEN: captured = stat_q;
        endcase
        stat_d  = wr_ok ? (captured & (wdata | ~IMPL_MASK)) : captured;
        state_d = (|stat_d) ? CAP_FROZEN : CAP_ARMED;
    end

    // outputs
    always_comb begin
        status = stat_q & IMPL_MASK;
        frozen = (state_q == CAP_FROZEN);
    end

endmodule

// File: rtl/reg_access.sv
module reg_access
    import errcap_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic              secure,
    input  logic              priv,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] rdata,
    output logic              acc_err,
    output logic              wr_ok
);

    logic allowed;

    always_comb begin
        allowed = secure && priv;
        acc_err = sel && !allowed;
        wr_ok   = sel && wr && allowed;
        rdata   = (sel && !wr && allowed) ? (status & IMPL_MASK) : '0;
    end

endmodule

// File: rtl/axi_err_capture.sv
module axi_err_capture
    import errcap_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [1:0]        rd_resp,
    input  logic              rd_last,
    input  logic              rd_route_miss,
    input  logic              rd_ilv_ok,
    input  logic              rd_cmd_mod,
    input  logic              wr_valid,
    input  logic [1:0]        wr_resp,
    input  logic              wr_route_miss,
    input  logic              wr_cmd_mod,
    input  logic              gated_hit,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_secure,
    input  logic              reg_priv,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_acc_err
);

    logic [RD_N-1:0]    rd_ev;
    logic [WR_N-1:0]    wr_ev;
    logic [STAT_W-1:0]  ev_all;
    logic [STAT_W-1:0]  status_q;
    logic               cap_frozen;
    logic               wr_ok;
    logic               rd_open;
    logic [ID_W-1:0]    rd_open_id;

    rd_err_detect #(.ID_W(ID_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_valid     (rd_valid),
        .rd_id        (rd_id),
        .rd_resp      (rd_resp),
        .rd_last      (rd_last),
        .rd_route_miss(rd_route_miss),
        .rd_ilv_ok    (rd_ilv_ok),
        .rd_cmd_mod   (rd_cmd_mod),
        .rd_ev        (rd_ev),
        .burst_open   (rd_open),
        .open_id      (rd_open_id)
    );

    wr_err_detect u_wr (
        .wr_valid     (wr_valid),
        .wr_resp      (wr_resp),
        .wr_route_miss(wr_route_miss),
        .wr_cmd_mod   (wr_cmd_mod),
        .wr_ev        (wr_ev)
    );

    // place the fault classes into their register groups
    always_comb begin
        ev_all = '0;
        for (int i = 0; i < RD_N; i++) ev_all[RD_BASE+i] = rd_ev[i];
        for (int i = 0; i < WR_N; i++) ev_all[WR_BASE+i] = wr_ev[i];
        ev_all[GATE_BIT] = gated_hit;
    end

    err_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_all),
        .wr_ok  (wr_ok),
        .wdata  (reg_wdata),
        .status (status_q),
        .frozen (cap_frozen)
    );

    reg_access u_acc (
        .sel    (reg_sel),
        .wr     (reg_wr),
        .secure (reg_secure),
        .priv   (reg_priv),
        .status (status_q),
        .rdata  (reg_rdata),
        .acc_err(reg_acc_err),
        .wr_ok  (wr_ok)
    );

endmodule

// File: rtl/err_capture_chk.sv
module err_capture_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [63:0]     status,
    input logic            frozen,
    input logic [63:0]     rdata,
    input logic            acc_err,
    input logic            sel,
    input logic            wr,
    input logic            secure,
    input logic            priv,
    input logic [63:0]     wdata,
    input logic            rd_valid,
    input logic [ID_W-1:0] rd_id,
    input logic            rd_ilv_ok,
    input logic            burst_open,
    input logic [ID_W-1:0] open_id,
    input logic            gated_hit
);

    localparam logic [63:0] UNUSED_MASK = ~64'h0000_0001_000F_001F;

    logic acc_ok;
    assign acc_ok = sel && wr && secure && priv;

    // R7: unused bits never read back as 1
    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & UNUSED_MASK) == 64'h0);

    // R9: the capture state agrees with the register contents
    assert_frozen_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frozen == (status != 64'h0));

    // R9: frozen and no accepted write -> status holds
    assert_hold_when_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !acc_ok) |=> $stable(status));

    // R10: frozen write keeps only bits written as 1
    assert_clear_by_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && acc_ok) |=> (status == ($past(status) & $past(wdata))));

    // R11: refused access reads zero and flags an error
    assert_refused_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !(secure && priv)) |-> (acc_err && rdata == 64'h0));

    // R4: foreign ID inside an open burst is captured when armed
    assert_interleave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && rd_valid && burst_open && (rd_id != open_id) && !rd_ilv_ok
         && !(acc_ok && !wdata[3])) |=> status[3]);

    // R6: gated-layer hit captured on the next edge when armed
    assert_gated_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && gated_hit && !(acc_ok && !wdata[32])) |=> status[32]);

endmodule

bind axi_err_capture err_capture_chk #(.ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (status_q),
    .frozen     (cap_frozen),
    .rdata      (reg_rdata),
    .acc_err    (reg_acc_err),
    .sel        (reg_sel),
    .wr         (reg_wr),
    .secure     (reg_secure),
    .priv       (reg_priv),
    .wdata      (reg_wdata),
    .rd_valid   (rd_valid),
    .rd_id      (rd_id),
    .rd_ilv_ok  (rd_ilv_ok),
    .burst_open (rd_open),
    .open_id    (rd_open_id),
    .gated_hit  (gated_hit)
);

// File: tb/sim_axi_err_capture.sv
module sim_axi_err_capture;

    localparam int CLK_PER = 10;
    localparam int ID_W    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_valid = 0, rd_last = 0, rd_route_miss = 0, rd_ilv_ok = 0, rd_cmd_mod = 0;
    logic [ID_W-1:0] rd_id = '0;
    logic [1:0]      rd_resp = '0;
    logic            wr_valid = 0, wr_route_miss = 0, wr_cmd_mod = 0, gated_hit = 0;
    logic [1:0]      wr_resp = '0;
    logic            reg_sel = 0, reg_wr = 0, reg_secure = 0, reg_priv = 0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic            reg_acc_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] data;
        logic        acc;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PER/2) clk = ~clk;

    axi_err_capture #(.ID_W(ID_W)) u0 (.*);

    // monitor: compare every register access at the falling edge
    always @(negedge clk) begin
        if (rst_n && reg_sel) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty rdata=%h exp=none", reg_rdata);
            end else begin
                e = sb.pop_front();
                if (reg_rdata !== e.data || reg_acc_err !== e.acc) begin
                    errors++;
                    $display("FAIL %s rdata=%h exp=%h acc_err=%b exp=%b",
                             e.req, reg_rdata, e.data, reg_acc_err, e.acc);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_beat(input logic [ID_W-1:0] id, input logic [1:0] resp,
                           input logic last, input logic miss, input logic ok);
        rd_valid = 1; rd_id = id; rd_resp = resp; rd_last = last;
        rd_route_miss = miss; rd_ilv_ok = ok;
        step();
        rd_valid = 0; rd_last = 0; rd_route_miss = 0; rd_ilv_ok = 0; rd_resp = '0;
    endtask

    task automatic wr_beat(input logic [1:0] resp, input logic miss);
        wr_valid = 1; wr_resp = resp; wr_route_miss = miss;
        step();
        wr_valid = 0; wr_resp = '0; wr_route_miss = 0;
    endtask

    task automatic pulses(input logic rm, input logic wm, input logic gh);
        rd_cmd_mod = rm; wr_cmd_mod = wm; gated_hit = gh;
        step();
        rd_cmd_mod = 0; wr_cmd_mod = 0; gated_hit = 0;
    endtask

    task automatic reg_read(input logic sec, input logic prv,
                            input logic [63:0] exp, input string req);
        exp_t e;
        e.data = exp; e.acc = !(sec && prv); e.req = req;
        sb.push_back(e);
        reg_sel = 1; reg_wr = 0; reg_secure = sec; reg_priv = prv;
        step();
        reg_sel = 0; reg_secure = 0; reg_priv = 0;
    endtask

    task automatic reg_write(input logic sec, input logic prv,
                             input logic [63:0] d, input string req);
        exp_t e;
        e.data = '0; e.acc = !(sec && prv); e.req = req;
        sb.push_back(e);
        reg_sel = 1; reg_wr = 1; reg_secure = sec; reg_priv = prv; reg_wdata = d;
        step();
        reg_sel = 0; reg_wr = 0; reg_secure = 0; reg_priv = 0; reg_wdata = '0;
    endtask

    task automatic clear_all();
        reg_write(1, 1, 64'h0, "R10 clear");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();

        // R7 reset state
        reg_read(1, 1, 64'h0, "R7 reset");

        // R1 read slave / decode error, R8 next-cycle visibility
        rd_beat(4'd1, 2'b10, 1, 0, 0);
        reg_read(1, 1, 64'h2, "R1 rd slverr");
        clear_all();
        reg_read(1, 1, 64'h0, "R10 cleared");
        rd_beat(4'd1, 2'b11, 1, 0, 0);
        reg_read(1, 1, 64'h1, "R1 rd decerr");
        clear_all();
        rd_beat(4'd2, 2'b01, 1, 0, 0);
        reg_read(1, 1, 64'h0, "R1 exokay clean");

        // R3 read route miss
        rd_beat(4'd2, 2'b00, 1, 1, 0);
        reg_read(1, 1, 64'h4, "R3 rd route miss");
        clear_all();

        // R5 write channel classes
        wr_beat(2'b11, 0);
        reg_read(1, 1, 64'h1_0000, "R5 wr decerr");
        clear_all();
        wr_beat(2'b10, 0);
        reg_read(1, 1, 64'h2_0000, "R5 wr slverr");
        clear_all();
        wr_beat(2'b00, 1);
        reg_read(1, 1, 64'h4_0000, "R5 wr route miss");
        clear_all();

        // R2 later beats ignored
        rd_beat(4'd3, 2'b00, 0, 0, 0);
        rd_beat(4'd3, 2'b10, 0, 0, 0);
        rd_beat(4'd3, 2'b11, 1, 0, 0);
        reg_read(1, 1, 64'h0, "R2 later beats ignored");
        rd_beat(4'd3, 2'b11, 0, 0, 0);
        rd_beat(4'd3, 2'b00, 1, 0, 0);
        reg_read(1, 1, 64'h1, "R2 first beat checked");
        clear_all();

        // R4 interleave
        rd_beat(4'd1, 2'b00, 0, 0, 0);
        rd_beat(4'd2, 2'b00, 1, 0, 0);
        rd_beat(4'd1, 2'b00, 1, 0, 0);
        reg_read(1, 1, 64'h8, "R4 interleave");
        clear_all();
        rd_beat(4'd1, 2'b00, 0, 0, 1);
        rd_beat(4'd2, 2'b00, 1, 0, 1);
        rd_beat(4'd1, 2'b00, 1, 0, 1);
        reg_read(1, 1, 64'h0, "R4 interleave allowed");

        // R3 R5 R6 R8 simultaneous capture
        pulses(1, 1, 1);
        reg_read(1, 1, 64'h0000_0001_0008_0010, "R8 simultaneous R3 R5 R6");

        // R9 frozen: new fault not recorded
        rd_beat(4'd5, 2'b11, 1, 0, 0);
        pulses(0, 0, 1);
        reg_read(1, 1, 64'h0000_0001_0008_0010, "R9 frozen");

        // R10 partial clear, then writing ones cannot set
        reg_write(1, 1, 64'h10, "R10 partial write");
        reg_read(1, 1, 64'h10, "R10 partial clear");
        reg_write(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R10 write ones");
        reg_read(1, 1, 64'h10, "R10 ones keep");

        // R11 protection
        reg_write(0, 1, 64'h0, "R11 nonsecure write");
        reg_write(1, 0, 64'h0, "R11 unpriv write");
        reg_read(0, 1, 64'h0, "R11 nonsecure read");
        reg_read(1, 0, 64'h0, "R11 unpriv read");
        reg_read(1, 1, 64'h10, "R11 status untouched");
        clear_all();

        // R7 unused bits ignore writes; R12 idle rdata
        reg_write(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R7 unused write");
        reg_read(1, 1, 64'h0, "R7 unused read zero");
        rd_beat(4'd1, 2'b10, 1, 0, 0);
        #2;
        checks++;
        if (reg_rdata !== 64'h0) begin
            errors++;
            $display("FAIL R12 idle rdata=%h exp=%h", reg_rdata, 64'h0);
        end
        reg_read(1, 1, 64'h2, "R12 read shows status");

        step();
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left=%0d exp=0", sb.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule